// File: doc/BRIEF.md
# Standby Entry and Release Controller

This block sits beside a small microcontroller core and handles its low-power standby. When the core executes a halt-type instruction, the block receives the 4-bit operand and a one-cycle execute strobe. It decodes the operand and checks the port condition that the chosen variant requires. It then either enters a clock-stopped standby (STOP) or a timer-running standby (HALT). If the operand is not legal, or its condition does not hold, it raises an internal reset instead.

While in STOP, the block watches the key input lines. In variants that allow it, it also watches three auxiliary pins, each gated by its own port configuration bit. While in HALT, it watches the timer down-counter for zero. On release it sends a single-cycle wake pulse to the core. A STOP request made while the timer is still running is held back until the counter and the timer output permit flag have both cleared. The block's own clock is always running. It drives a clock-enable output that the clock-gating logic outside the block uses.

Top module: `stdby_ctrl`

## Requirements
- R1: In reset and in the first cycle after reset, `clk_en` is 1, `wake` is 0 and `int_rst` is 0.
- R2: The low three operand bits decide the variant. 000 and 011 request STOP. 110 requests STOP. 101 requests HALT, whatever bit 3 holds. Any other low pattern (001, 010, 100, 111) raises `int_rst` in the cycle after the strobe and enters no standby.
- R3: For low patterns 000 and 011, every key I/O line must have direction 1 (output) and level 1. Otherwise `int_rst` is raised instead of entering STOP.
- R4: For low pattern 110, only line 0 is checked: direction 1 and level 1 on line 0. The other lines may hold any value. If line 0 fails the check, `int_rst` is raised.
- R5: An accepted STOP with the timer idle drives `clk_en` to 0 in the cycle after the strobe. A high level on any key input, seen through a 2-stage synchronizer, releases STOP: three cycles after the level arrives, `clk_en` returns to 1 and `wake` is 1 for exactly one cycle.
- R6: When operand bit 3 is 1 in a STOP variant, the auxiliary pins are extra release sources. Pin 0 counts only if config bit 0 is 1, pin 1 only if config bit 2 is 1, and pin 2 only if config bit 3 is 1. When operand bit 3 is 0, the auxiliary pins have no effect.
- R7: In HALT, `clk_en` stays 1. `wake` pulses in the cycle after the timer count is seen at zero.
- R8: If the timer count is nonzero, or the permit flag is 1, when STOP is accepted, `clk_en` stays 1. It drops in the cycle after both the count and the flag are seen at 0.
- R9: `int_rst` stays high for exactly RST_CYC cycles (4 by default). An execute strobe is ignored while `int_rst` is high and while the block is in standby.
- R10: If a release level is already synchronized when STOP is entered, `wake` pulses in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_halt | input | 1 | One-cycle strobe: a halt-type instruction executes |
| halt_op | input | 4 | Instruction operand; bit 3 enables auxiliary release |
| kio_dir | input | KIO_W | Key I/O line direction, 1 = output |
| kio_lvl | input | KIO_W | Key I/O line output level |
| key_in | input | KIN_W | Key input lines, asynchronous |
| aux_pin | input | 3 | Auxiliary release pins, asynchronous |
| port_cfg | input | 4 | Port configuration bits: 0, 2 and 3 enable auxiliary pins 0, 1 and 2 |
| tmr_cnt | input | TMR_W | Timer down-counter value |
| tmr_permit | input | 1 | Timer output permit flag |
| clk_en | output | 1 | Core clock enable, low only in STOP |
| wake | output | 1 | One-cycle wake pulse to the core |
| int_rst | output | 1 | Internal reset request |

## Verification
The bench builds the block with 4 key I/O lines, 4 key inputs, a 10-bit timer and a 4-cycle reset. With these values every operand pattern and every direction/level combination that matters can be written as a short table row. With a 4-line port, a row can pass the check on line 0 while failing it on the other lines, which tells the 110 variant apart from the all-lines variants. A 4-cycle reset length makes it possible to issue an execute strobe while the reset is still high and observe that it is dropped.

// File: rtl/stdby_pkg.sv
package stdby_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WAIT_CLR = 2'd1,
        ST_STOP     = 2'd2,
        ST_HALT     = 2'd3
    } sb_state_e;

    typedef struct packed {
        logic legal;
        logic to_stop;
        logic io0_only;
        logic aux_arm;
    } sb_dec_t;

    localparam int CFG_AUX0_BIT = 0;
    localparam int CFG_AUX1_BIT = 2;
    localparam int CFG_AUX2_BIT = 3;

    function automatic sb_dec_t sb_decode(input logic [3:0] op);
        sb_dec_t d;
        d = '0;
        unique case (op[2:0])
            3'b000, 3'b011: begin
                d.legal   = 1'b1;
                d.to_stop = 1'b1;
            end
            3'b110: begin
                d.legal    = 1'b1;
                d.to_stop  = 1'b1;
                d.io0_only = 1'b1;
            end
            3'b101: d.legal = 1'b1;
            default: d = '0;
        endcase
        d.aux_arm = op[3] & d.to_stop;
        return d;
    endfunction

endpackage

// File: rtl/stdby_sync.sv
module stdby_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stdby_wake_src.sv
module stdby_wake_src #(
    parameter int KIN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KIN_W-1:0] key_in,
    input  logic [2:0]       aux_pin,
    input  logic [2:0]       aux_en,
    input  logic             aux_armed,
    output logic             release_lvl
);
    localparam int SW = KIN_W + 3;

    logic [SW-1:0] raw_w, syn_w;
    logic [KIN_W-1:0] key_s;
    logic [2:0] aux_s;

    assign raw_w = {aux_pin, key_in};

    stdby_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_w),
        .q   (syn_w)
    );

    assign key_s = syn_w[KIN_W-1:0];
    assign aux_s = syn_w[SW-1:KIN_W];

    assign release_lvl = (|key_s) | (aux_armed & |(aux_s & aux_en));
endmodule

// File: rtl/stdby_rst_stretch.sv
module stdby_rst_stretch #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (trig) cnt_q <= CW'(RST_CYC);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/stdby_ctrl.sv
module stdby_ctrl
    import stdby_pkg::*;
#(
    parameter int KIO_W       = 4,
    parameter int KIN_W       = 4,
    parameter int TMR_W       = 10,
    parameter int RST_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_halt,
    input  logic [3:0]       halt_op,
    input  logic [KIO_W-1:0] kio_dir,
    input  logic [KIO_W-1:0] kio_lvl,
    input  logic [KIN_W-1:0] key_in,
    input  logic [2:0]       aux_pin,
    input  logic [3:0]       port_cfg,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic             tmr_permit,
    output logic             clk_en,
    output logic             wake,
    output logic             int_rst
);
    sb_state_e state_q, state_d;
    sb_dec_t   dec;
    logic      aux_q, aux_d;
    logic      wake_q, wake_d;
    logic      all_hi, io0_hi, pre_ok;
    logic      accept, bad_req;
    logic      tmr_busy, tmr_zero;
    logic      release_lvl;
    logic [2:0] aux_en;
    logic      cfg_unused;

    assign dec    = sb_decode(halt_op);
    assign all_hi = (&kio_dir) & (&kio_lvl);
    assign io0_hi = kio_dir[0] & kio_lvl[0];
    assign pre_ok = dec.io0_only ? io0_hi : all_hi;

    assign accept  = exec_halt && (state_q == ST_RUN) && !int_rst;
    assign bad_req = accept && (!dec.legal || (dec.to_stop && !pre_ok));

    assign tmr_zero = (tmr_cnt == '0);
    assign tmr_busy = !tmr_zero || tmr_permit;

    assign aux_en     = {port_cfg[CFG_AUX2_BIT], port_cfg[CFG_AUX1_BIT], port_cfg[CFG_AUX0_BIT]};
    assign cfg_unused = port_cfg[1];

    stdby_wake_src #(.KIN_W(KIN_W), .SYNC_STAGES(SYNC_STAGES)) u_wsrc (
        .clk         (clk),
        .rst         (rst),
        .key_in      (key_in),
        .aux_pin     (aux_pin),
        .aux_en      (aux_en),
        .aux_armed   (aux_q),
        .release_lvl (release_lvl)
    );

    stdby_rst_stretch #(.RST_CYC(RST_CYC)) u_rst (
        .clk    (clk),
        .rst    (rst),
        .trig   (bad_req),
        .active (int_rst)
    );

    always_comb begin
        state_d = state_q;
        aux_d   = aux_q;
        wake_d  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (accept && !bad_req) begin
                    if (!dec.to_stop) begin
                        state_d = ST_HALT;
                    end else begin
                        aux_d   = dec.aux_arm;
                        state_d = tmr_busy ? ST_WAIT_CLR : ST_STOP;
                    end
                end
            end
            ST_WAIT_CLR: if (!tmr_busy) state_d = ST_STOP;
            ST_STOP: begin
                if (release_lvl) begin
                    state_d = ST_RUN;
                    aux_d   = 1'b0;
                    wake_d  = 1'b1;
                end
            end
            ST_HALT: begin
                if (tmr_zero) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            aux_q   <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            aux_q   <= aux_d;
            wake_q  <= wake_d;
        end
    end

    assign clk_en = (state_q != ST_STOP);
    assign wake   = wake_q;
endmodule

// File: rtl/stdby_ctrl_chk.sv
module stdby_ctrl_chk
    import stdby_pkg::*;
#(
    parameter int TMR_W   = 10,
    parameter int RST_CYC = 4
) (
    input logic             clk,
    input logic             rst,
    input sb_state_e        state,
    input logic [TMR_W-1:0] tmr_cnt,
    input logic             tmr_permit,
    input logic             clk_en,
    input logic             wake,
    input logic             int_rst
);
    localparam int LW = $clog2(RST_CYC + 2);

    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else if (int_rst) run_len <= run_len + 1'b1;
        else run_len <= '0;
    end

    p_wake_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    p_wake_from_standby_r5: assert property (@(posedge clk) disable iff (rst)
        wake |-> ($past(state) == ST_STOP || $past(state) == ST_HALT));

    p_halt_wake_timer_r7: assert property (@(posedge clk) disable iff (rst)
        (wake && $past(state) == ST_HALT) |-> ($past(tmr_cnt) == '0));

    p_stop_after_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> ($past(tmr_cnt) == '0 && !$past(tmr_permit)));

    p_rst_not_too_long_r9: assert property (@(posedge clk) disable iff (rst)
        int_rst |-> (run_len < LW'(RST_CYC)));

    p_rst_full_length_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(int_rst) |-> (run_len == LW'(RST_CYC)));

    p_no_rst_in_stop_r9: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> !int_rst);
endmodule

bind stdby_ctrl stdby_ctrl_chk #(.TMR_W(TMR_W), .RST_CYC(RST_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state_q),
    .tmr_cnt    (tmr_cnt),
    .tmr_permit (tmr_permit),
    .clk_en     (clk_en),
    .wake       (wake),
    .int_rst    (int_rst)
);

// File: tb/stdby_ctrl_tb_top.sv
module stdby_ctrl_tb_top;
    localparam int KIO_W   = 4;
    localparam int KIN_W   = 4;
    localparam int TMR_W   = 10;
    localparam int RST_CYC = 4;
    localparam int NV      = 18;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] dir;
        logic [3:0] lvl;
        logic [3:0] cfg;
        logic [2:0] s;
        logic [3:0] key;
        logic       e_rst;
        logic       e_wake;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{4'b0000, 4'hF, 4'hF, 4'h0, 3'b000, 4'b0001, 1'b0, 1'b1},
        '{4'b0011, 4'hF, 4'hF, 4'h0, 3'b000, 4'b1000, 1'b0, 1'b1},
        '{4'b0000, 4'hF, 4'h7, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0011, 4'h7, 4'hF, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0110, 4'h1, 4'h1, 4'h0, 3'b000, 4'b0100, 1'b0, 1'b1},
        '{4'b0110, 4'h1, 4'h0, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0110, 4'hE, 4'hE, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0001, 4'hF, 4'hF, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0010, 4'hF, 4'hF, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0100, 4'hF, 4'hF, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b0111, 4'hF, 4'hF, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b1111, 4'hF, 4'hF, 4'h0, 3'b000, 4'b0000, 1'b1, 1'b0},
        '{4'b1000, 4'hF, 4'hF, 4'h1, 3'b001, 4'b0000, 1'b0, 1'b1},
        '{4'b1000, 4'hF, 4'hF, 4'h4, 3'b010, 4'b0000, 1'b0, 1'b1},
        '{4'b1011, 4'hF, 4'hF, 4'h8, 3'b100, 4'b0000, 1'b0, 1'b1},
        '{4'b1110, 4'h1, 4'h1, 4'h0, 3'b111, 4'b0000, 1'b0, 1'b0},
        '{4'b0000, 4'hF, 4'hF, 4'hD, 3'b111, 4'b0000, 1'b0, 1'b0},
        '{4'b1000, 4'hF, 4'hF, 4'h1, 3'b010, 4'b0000, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             exec_halt;
    logic [3:0]       halt_op;
    logic [KIO_W-1:0] kio_dir, kio_lvl;
    logic [KIN_W-1:0] key_in;
    logic [2:0]       aux_pin;
    logic [3:0]       port_cfg;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_permit;
    logic             clk_en, wake, int_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    stdby_ctrl #(.KIO_W(KIO_W), .KIN_W(KIN_W), .TMR_W(TMR_W), .RST_CYC(RST_CYC)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .exec_halt  (exec_halt),
        .halt_op    (halt_op),
        .kio_dir    (kio_dir),
        .kio_lvl    (kio_lvl),
        .key_in     (key_in),
        .aux_pin    (aux_pin),
        .port_cfg   (port_cfg),
        .tmr_cnt    (tmr_cnt),
        .tmr_permit (tmr_permit),
        .clk_en     (clk_en),
        .wake       (wake),
        .int_rst    (int_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_exec(input logic [3:0] op);
        halt_op   = op;
        exec_halt = 1'b1;
        @(negedge clk);
        exec_halt = 1'b0;
    endtask

    task automatic settle();
        key_in  = '0;
        aux_pin = '0;
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; exec_halt = 1'b0; halt_op = '0;
        kio_dir = '1; kio_lvl = '1; key_in = '0; aux_pin = '0;
        port_cfg = '0; tmr_cnt = '0; tmr_permit = 1'b0;
        tick(3);
        chk("R1 clk_en in reset", 32'(clk_en), 32'd1);
        chk("R1 wake in reset", 32'(wake), 32'd0);
        chk("R1 int_rst in reset", 32'(int_rst), 32'd0);
        rst = 1'b0;
        tick(1);
        chk("R1 clk_en after reset", 32'(clk_en), 32'd1);
        chk("R1 int_rst after reset", 32'(int_rst), 32'd0);

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            kio_dir  = TBL[i].dir;
            kio_lvl  = TBL[i].lvl;
            port_cfg = TBL[i].cfg;
            do_exec(TBL[i].op);
            chk("R2 R3 R4 int_rst after strobe", 32'(int_rst), 32'(TBL[i].e_rst));
            chk("R2 R5 clk_en after strobe", 32'(clk_en), 32'(TBL[i].e_rst));
            if (TBL[i].e_rst) begin
                tick(RST_CYC);
                chk("R9 int_rst released", 32'(int_rst), 32'd0);
            end else begin
                key_in  = TBL[i].key;
                aux_pin = TBL[i].s;
                tick(3);
                chk("R5 R6 wake on release", 32'(wake), 32'(TBL[i].e_wake));
                chk("R5 R6 clk_en on release", 32'(clk_en), 32'(TBL[i].e_wake));
                if (!TBL[i].e_wake) begin
                    aux_pin = '0;
                    key_in  = 4'b0001;
                    tick(3);
                    chk("R5 key release after ignored aux", 32'(wake), 32'd1);
                    tick(1);
                    chk("R5 wake one cycle", 32'(wake), 32'd0);
                end
            end
            settle();
        end

        // R7 HALT with timer running, bit 3 set and clear
        kio_dir = '0; kio_lvl = '0;
        for (int b = 0; b < 2; b++) begin
            tmr_cnt = 10'd5;
            do_exec({b[0], 3'b101});
            chk("R7 HALT no reset", 32'(int_rst), 32'd0);
            chk("R7 HALT keeps clock", 32'(clk_en), 32'd1);
            tick(2);
            chk("R7 HALT waits on timer", 32'(wake), 32'd0);
            tmr_cnt = '0;
            tick(1);
            chk("R7 HALT wake at timer zero", 32'(wake), 32'd1);
            tick(1);
            chk("R7 wake single pulse", 32'(wake), 32'd0);
            settle();
        end

        // R8 deferred STOP
        kio_dir = '1; kio_lvl = '1; port_cfg = '0;
        tmr_cnt = 10'd3;
        do_exec(4'b0000);
        chk("R8 clock kept while timer busy", 32'(clk_en), 32'd1);
        tmr_cnt = '0; tmr_permit = 1'b1;
        tick(2);
        chk("R8 clock kept while permit set", 32'(clk_en), 32'd1);
        tmr_permit = 1'b0;
        tick(1);
        chk("R8 stop after timer clear", 32'(clk_en), 32'd0);
        key_in = 4'b0010;
        tick(3);
        chk("R8 release after deferred stop", 32'(wake), 32'd1);
        settle();

        // R10 release already active at entry
        key_in = 4'b0010;
        tick(3);
        do_exec(4'b0011);
        chk("R10 stop entered", 32'(clk_en), 32'd0);
        tick(1);
        chk("R10 immediate wake", 32'(wake), 32'd1);
        chk("R10 clock back", 32'(clk_en), 32'd1);
        settle();

        // R9 reset length and strobe ignored during reset
        do_exec(4'b0001);
        chk("R9 reset cycle 1", 32'(int_rst), 32'd1);
        do_exec(4'b0000);
        chk("R9 strobe ignored in reset", 32'(clk_en), 32'd1);
        tick(2);
        chk("R9 reset cycle 4", 32'(int_rst), 32'd1);
        tick(1);
        chk("R9 reset ends after RST_CYC", 32'(int_rst), 32'd0);
        chk("R9 still running", 32'(clk_en), 32'd1);
        tick(2);

        // R9 strobe ignored in STOP
        do_exec(4'b0000);
        chk("R9 stop entered", 32'(clk_en), 32'd0);
        do_exec(4'b0001);
        chk("R9 illegal strobe ignored in stop", 32'(int_rst), 32'd0);
        chk("R9 stop held", 32'(clk_en), 32'd0);
        key_in = 4'b0100;
        tick(3);
        chk("R5 release", 32'(wake), 32'd1);
        settle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule